// File: doc/BRIEF.md
# Sv39 Translation Cache with Superpage Masking

This block is a small fully associative cache of completed 39-bit virtual to 56-bit physical address translations. Each slot records the address space identifier, a global flag, the virtual page with its low bits cleared according to the leaf level, the physical page, the eight attribute bits of the leaf entry, and the physical address where that leaf entry lives, for later dirty-bit write-back. Each slot also records a fill time-stamp, taken from a free-running cycle counter.

A lookup strobe presents an identifier and a virtual address. One cycle later the block reports hit or miss. On a hit it also returns the translated physical address, the attributes and the leaf-entry address. A fill writes one walk result, including its leaf level (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB; other values are not to be used). The slot it takes is an invalid slot, or else the one filled longest ago. A flush invalidates entries selectively. Which entries it removes depends on whether an identifier, an address, both or neither are supplied, and on each entry's global flag.

Top module: `sv39_tlb`

## Requirements
- R1: After reset every slot is invalid and `rsp_valid` is 0, so any later lookup misses until a fill occurs.
- R2: `rsp_valid` is 1 in exactly the cycle after `lk_valid` was 1. A miss returns `rsp_hit`=0 with `rsp_paddr`, `rsp_attr` and `rsp_pte_addr` all zero.
- R3: An entry matches a lookup only when it is global or its stored identifier equals `lk_asid`.
- R4: For leaf level L the low 12+9L bits of the virtual address are ignored in matching, and the low 12+9L bits of the filled physical address are discarded. A hit returns the stored physical page ORed with those low bits taken from `lk_vaddr`.
- R5: A hit returns the attribute byte and the leaf-entry address given at fill.
- R6: A flush with `flush_use_asid`=0 and `flush_use_addr`=0 invalidates every slot.
- R7: A flush with only `flush_use_addr`=1 invalidates every entry whose page covers `flush_vaddr`, global entries included.
- R8: A flush with only `flush_use_asid`=1 invalidates the non-global entries whose identifier equals `flush_asid`; global entries survive.
- R9: A flush with both selects set invalidates only the non-global entries that match both the identifier and the address.
- R10: A fill takes the lowest-numbered invalid slot. When all slots are valid, it replaces the slot with the oldest fill time-stamp.
- R11: A fill in the same cycle as a flush is dropped.
- R12: A lookup in the same cycle as a fill or flush sees the slot contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_asid | input | 16 | Lookup address space identifier |
| lk_vaddr | input | 39 | Lookup virtual address |
| fill_valid | input | 1 | Fill strobe |
| fill_asid | input | 16 | Identifier of the walk result |
| fill_global | input | 1 | Walk result is global |
| fill_level | input | 2 | Leaf level 0..2 |
| fill_vaddr | input | 39 | Virtual address that was walked |
| fill_paddr | input | 56 | Physical address from the leaf entry |
| fill_attr | input | 8 | Leaf entry attribute bits |
| fill_pte_addr | input | 56 | Physical address of the leaf entry |
| flush_valid | input | 1 | Flush strobe |
| flush_use_asid | input | 1 | Flush is restricted to an identifier |
| flush_asid | input | 16 | Identifier for the flush |
| flush_use_addr | input | 1 | Flush is restricted to an address |
| flush_vaddr | input | 39 | Virtual address for the flush |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 56 | Translated physical address |
| rsp_attr | output | 8 | Attribute bits of the hit entry |
| rsp_pte_addr | output | 56 | Leaf-entry address of the hit entry |

## Verification
The assertions check the following on every cycle:
- The response follows each strobe by one cycle.
- A miss returns zeros.
- A hit carries the request's 12-bit page offset unchanged.
- A full flush empties all slots even when a fill arrives with it.
- A fill with free space adds exactly one valid slot, and a fill into a full cache leaves it full.

Only the bench scenarios can show which entry a given flush mode removes, how the global flag and identifier gate matching, superpage translation, and that the oldest entry is the one evicted. The bench does this by comparing each response with a reference table kept alongside the random and directed traffic.

// File: rtl/sv39_tlb_pkg.sv
// Package: shared widths, the slot record, the fill record and the
// offset-mask function used by every part of the translation cache.
// Assumes leaf levels 0..2 of a three-level 39-bit scheme.
package sv39_tlb_pkg;
    localparam int VA_W     = 39;
    localparam int PA_W     = 56;
    localparam int ASID_W   = 16;
    localparam int ATTR_W   = 8;
    localparam int LVL_W    = 2;
    localparam int PG_BITS  = 12;
    localparam int LVL_BITS = 9;
    localparam int EXT_W    = PA_W - VA_W;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VA_W-1:0]   vpage;
        logic [VA_W-1:0]   omask;
        logic [PA_W-1:0]   ppage;
        logic [ATTR_W-1:0] attr;
        logic [PA_W-1:0]   pte_addr;
    } slot_t;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [LVL_W-1:0]  level;
        logic [VA_W-1:0]   vaddr;
        logic [PA_W-1:0]   paddr;
        logic [ATTR_W-1:0] attr;
        logic [PA_W-1:0]   pte_addr;
    } fill_t;

    // Bits below the page boundary of the given leaf level.
    function automatic logic [VA_W-1:0] offset_mask(input logic [LVL_W-1:0] lvl);
        logic [VA_W-1:0] one;
        one = '0;
        one[0] = 1'b1;
        return (one << (PG_BITS + LVL_BITS * int'(lvl))) - one;
    endfunction
endpackage

// File: rtl/sv39_tlb_entry.sv
// One cache slot: holds a translation, matches lookups against it and
// decides whether a flush removes it. Assumes the top never asserts
// wr_en together with fl_en.
module sv39_tlb_entry
    import sv39_tlb_pkg::*;
#(
    parameter int AGE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  fill_t             wr_req,
    input  logic [AGE_W-1:0]  wr_age,
    input  logic              fl_en,
    input  logic              fl_use_asid,
    input  logic              fl_use_addr,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [VA_W-1:0]   fl_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              valid,
    output logic [AGE_W-1:0]  age,
    output logic              hit,
    output logic [PA_W-1:0]   xlat_paddr,
    output logic [ATTR_W-1:0] attr,
    output logic [PA_W-1:0]   pte_addr
);
    slot_t            slot_q;
    logic             valid_q;
    logic [AGE_W-1:0] age_q;
    logic [VA_W-1:0]  new_mask;
    logic             fl_addr_m;
    logic             fl_asid_m;
    logic             kill;

    // Offset mask of the incoming walk result.
    always_comb new_mask = offset_mask(wr_req.level);

    // Slot contents: captured on a fill, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            age_q  <= '0;
        end else if (wr_en) begin
            slot_q.asid     <= wr_req.asid;
            slot_q.glob     <= wr_req.glob;
            slot_q.vpage    <= wr_req.vaddr & ~new_mask;
            slot_q.omask    <= new_mask;
            slot_q.ppage    <= wr_req.paddr & ~{{EXT_W{1'b0}}, new_mask};
            slot_q.attr     <= wr_req.attr;
            slot_q.pte_addr <= wr_req.pte_addr;
            age_q           <= wr_age;
        end
    end

    // Flush selection for the four combinations of identifier and address.
    always_comb begin
        fl_addr_m = (slot_q.vpage == (fl_vaddr & ~slot_q.omask));
        fl_asid_m = (slot_q.asid == fl_asid);
        unique case ({fl_use_asid, fl_use_addr})
            2'b00:   kill = 1'b1;
            2'b01:   kill = fl_addr_m;
            2'b10:   kill = !slot_q.glob && fl_asid_m;
            default: kill = !slot_q.glob && fl_asid_m && fl_addr_m;
        endcase
    end

    // Valid bit: flush clears it, fill sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)              valid_q <= 1'b0;
        else if (fl_en && kill)  valid_q <= 1'b0;
        else if (wr_en)          valid_q <= 1'b1;
    end

    // Lookup match and translated address.
    always_comb begin
        hit = valid_q && (slot_q.glob || (slot_q.asid == lk_asid))
              && (slot_q.vpage == (lk_vaddr & ~slot_q.omask));
        xlat_paddr = slot_q.ppage | {{EXT_W{1'b0}}, lk_vaddr & slot_q.omask};
    end

    assign valid    = valid_q;
    assign age      = age_q;
    assign attr     = slot_q.attr;
    assign pte_addr = slot_q.pte_addr;
endmodule

// File: rtl/sv39_tlb_victim.sv
// Replacement choice: the lowest-numbered invalid slot, otherwise the
// slot with the smallest fill stamp (ties go to the lower index).
// Assumes the stamp counter does not wrap within a slot's lifetime.
module sv39_tlb_victim #(
    parameter int N     = 4,
    parameter int AGE_W = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [AGE_W-1:0] age [N],
    output logic [IDX_W-1:0] idx
);
    logic             found;
    logic [AGE_W-1:0] best;

    // Scan for a free slot first, then for the oldest.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        best  = age[0];
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 1; i < N; i++) begin
                if (age[i] < best) begin
                    best = age[i];
                    idx  = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/sv39_tlb.sv
// Top: fully associative 39-bit translation cache. It issues fills to the
// chosen slot, broadcasts flushes and registers the lookup response one
// cycle after the strobe. Assumes fill_level is 0..2 and that at most one
// slot holds a given page (the lowest index wins otherwise).
module sv39_tlb
    import sv39_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    parameter int AGE_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [PA_W-1:0]   fill_paddr,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic [PA_W-1:0]   fill_pte_addr,
    input  logic              flush_valid,
    input  logic              flush_use_asid,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              flush_use_addr,
    input  logic [VA_W-1:0]   flush_vaddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic [PA_W-1:0]   rsp_pte_addr
);
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    fill_t              fill_req;
    logic [AGE_W-1:0]   stamp_q;
    logic [N_ENTRIES-1:0] ent_valid;
    logic [N_ENTRIES-1:0] ent_hit;
    logic [AGE_W-1:0]   ent_age   [N_ENTRIES];
    logic [PA_W-1:0]    ent_xlat  [N_ENTRIES];
    logic [ATTR_W-1:0]  ent_attr  [N_ENTRIES];
    logic [PA_W-1:0]    ent_pte   [N_ENTRIES];
    logic [IDX_W-1:0]   victim;
    logic               do_fill;
    logic               sel_hit;
    logic [PA_W-1:0]    sel_pa;
    logic [ATTR_W-1:0]  sel_attr;
    logic [PA_W-1:0]    sel_pte;

    // Pack the walk result.
    always_comb begin
        fill_req.asid     = fill_asid;
        fill_req.glob     = fill_global;
        fill_req.level    = fill_level;
        fill_req.vaddr    = fill_vaddr;
        fill_req.paddr    = fill_paddr;
        fill_req.attr     = fill_attr;
        fill_req.pte_addr = fill_pte_addr;
    end

    // A flush in the same cycle wins over a fill.
    assign do_fill = fill_valid && !flush_valid;

    // Free-running fill time-stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_q + AGE_W'(1);
    end

    sv39_tlb_victim #(.N(N_ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_victim (
        .valid (ent_valid),
        .age   (ent_age),
        .idx   (victim)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        sv39_tlb_entry #(.AGE_W(AGE_W)) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (do_fill && (victim == IDX_W'(g))),
            .wr_req      (fill_req),
            .wr_age      (stamp_q),
            .fl_en       (flush_valid),
            .fl_use_asid (flush_use_asid),
            .fl_use_addr (flush_use_addr),
            .fl_asid     (flush_asid),
            .fl_vaddr    (flush_vaddr),
            .lk_asid     (lk_asid),
            .lk_vaddr    (lk_vaddr),
            .valid       (ent_valid[g]),
            .age         (ent_age[g]),
            .hit         (ent_hit[g]),
            .xlat_paddr  (ent_xlat[g]),
            .attr        (ent_attr[g]),
            .pte_addr    (ent_pte[g])
        );
    end

    // Pick the lowest-numbered matching slot.
    always_comb begin
        sel_hit  = 1'b0;
        sel_pa   = '0;
        sel_attr = '0;
        sel_pte  = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (ent_hit[i] && !sel_hit) begin
                sel_hit  = 1'b1;
                sel_pa   = ent_xlat[i];
                sel_attr = ent_attr[i];
                sel_pte  = ent_pte[i];
            end
        end
    end

    // Registered lookup response; zeros on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_paddr    <= '0;
            rsp_attr     <= '0;
            rsp_pte_addr <= '0;
        end else begin
            rsp_valid    <= lk_valid;
            rsp_hit      <= lk_valid && sel_hit;
            rsp_paddr    <= (lk_valid && sel_hit) ? sel_pa   : '0;
            rsp_attr     <= (lk_valid && sel_hit) ? sel_attr : '0;
            rsp_pte_addr <= (lk_valid && sel_hit) ? sel_pte  : '0;
        end
    end
endmodule

// File: rtl/sv39_tlb_chk.sv
// Checker: cycle-level properties of the translation cache, bound to
// every instance of the top. Assumes synchronous active-low reset.
module sv39_tlb_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_valid,
    input logic [38:0]  lk_vaddr,
    input logic         fill_valid,
    input logic         flush_valid,
    input logic         flush_use_asid,
    input logic         flush_use_addr,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic [55:0]  rsp_paddr,
    input logic [7:0]   rsp_attr,
    input logic [55:0]  rsp_pte_addr,
    input logic [N-1:0] ent_valid
);
    a_r2_rsp_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r2_no_rsp_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_attr == '0 && rsp_pte_addr == '0));
    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[11:0] == $past(lk_vaddr[11:0])));
    a_r6_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_use_asid && !flush_use_addr) |=> (ent_valid == '0));
    a_r10_fill_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_valid && !(&ent_valid))
        |=> ($countones(ent_valid) == $countones($past(ent_valid)) + 1));
    a_r10_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_valid && (&ent_valid)) |=> (&ent_valid));
endmodule

bind sv39_tlb sv39_tlb_chk #(.N(N_ENTRIES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_vaddr       (lk_vaddr),
    .fill_valid     (fill_valid),
    .flush_valid    (flush_valid),
    .flush_use_asid (flush_use_asid),
    .flush_use_addr (flush_use_addr),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_paddr      (rsp_paddr),
    .rsp_attr       (rsp_attr),
    .rsp_pte_addr   (rsp_pte_addr),
    .ent_valid      (ent_valid)
);

// File: tb/sv39_tlb_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, each lookup
// compared with a reference table kept from the requirements.
module sv39_tlb_bench;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0;
    logic [15:0] lk_asid = '0;
    logic [38:0] lk_vaddr = '0;
    logic        fill_valid = 0;
    logic [15:0] fill_asid = '0;
    logic        fill_global = 0;
    logic [1:0]  fill_level = '0;
    logic [38:0] fill_vaddr = '0;
    logic [55:0] fill_paddr = '0;
    logic [7:0]  fill_attr = '0;
    logic [55:0] fill_pte_addr = '0;
    logic        flush_valid = 0;
    logic        flush_use_asid = 0;
    logic [15:0] flush_asid = '0;
    logic        flush_use_addr = 0;
    logic [38:0] flush_vaddr = '0;
    logic        rsp_valid, rsp_hit;
    logic [55:0] rsp_paddr, rsp_pte_addr;
    logic [7:0]  rsp_attr;

    int checks = 0;
    int failures = 0;

    // Reference table
    bit          m_val [NE];
    logic [15:0] m_asid [NE];
    bit          m_glob [NE];
    logic [38:0] m_vp [NE];
    logic [38:0] m_mask [NE];
    logic [55:0] m_pp [NE];
    logic [7:0]  m_attr [NE];
    logic [55:0] m_pte [NE];
    int          m_seq [NE];
    int          seq_n = 0;

    always #10 clk = ~clk;

    sv39_tlb u_sv39_tlb (.*);

    function automatic logic [38:0] lvl_mask(input logic [1:0] l);
        return (39'd1 << (12 + 9 * int'(l))) - 39'd1;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: called at a falling edge with strobes already driven.
    task automatic step(input string tag);
        bit          e_hit = 0;
        logic [55:0] e_pa = '0, e_pte = '0;
        logic [7:0]  e_at = '0;
        bool_lk: begin end
        for (int i = 0; i < NE; i++) begin
            if (!e_hit && m_val[i] && (m_glob[i] || m_asid[i] == lk_asid)
                && m_vp[i] == (lk_vaddr & ~m_mask[i])) begin
                e_hit = 1;
                e_pa  = m_pp[i] | {17'b0, lk_vaddr & m_mask[i]};
                e_at  = m_attr[i];
                e_pte = m_pte[i];
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (lk_valid) begin
            check({tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
            check({tag, " hit"}, 64'(rsp_hit), 64'(e_hit));
            check({tag, " paddr"}, 64'(rsp_paddr), 64'(e_pa));
            if (e_hit) begin
                check({tag, " R5 attr"}, 64'(rsp_attr), 64'(e_at));
                check({tag, " R5 pte"}, 64'(rsp_pte_addr), 64'(e_pte));
            end
        end else begin
            check({tag, " R2 idle"}, 64'(rsp_valid), 64'd0);
        end
        // Reference update: flush first; a fill with a flush is dropped (R11).
        if (flush_valid) begin
            for (int i = 0; i < NE; i++) begin
                bit am = (m_vp[i] == (flush_vaddr & ~m_mask[i]));
                bit sm = (m_asid[i] == flush_asid);
                bit k;
                case ({flush_use_asid, flush_use_addr})
                    2'b00: k = 1;
                    2'b01: k = am;
                    2'b10: k = !m_glob[i] && sm;
                    default: k = !m_glob[i] && sm && am;
                endcase
                if (k) m_val[i] = 0;
            end
        end else if (fill_valid) begin
            int v = -1;
            for (int i = 0; i < NE; i++) if (v < 0 && !m_val[i]) v = i;
            if (v < 0) begin
                v = 0;
                for (int i = 1; i < NE; i++) if (m_seq[i] < m_seq[v]) v = i;
            end
            m_val[v]  = 1;
            m_asid[v] = fill_asid;
            m_glob[v] = fill_global;
            m_mask[v] = lvl_mask(fill_level);
            m_vp[v]   = fill_vaddr & ~lvl_mask(fill_level);
            m_pp[v]   = fill_paddr & ~{17'b0, lvl_mask(fill_level)};
            m_attr[v] = fill_attr;
            m_pte[v]  = fill_pte_addr;
            m_seq[v]  = seq_n++;
        end
        lk_valid = 0;
        fill_valid = 0;
        flush_valid = 0;
    endtask

    task automatic set_fill(input logic [15:0] a, input bit g, input logic [1:0] l,
                            input logic [38:0] va, input logic [55:0] pa, input logic [7:0] at);
        fill_valid = 1; fill_asid = a; fill_global = g; fill_level = l;
        fill_vaddr = va; fill_paddr = pa; fill_attr = at;
        fill_pte_addr = {pa[55:3], 3'b000} ^ 56'h1000;
    endtask

    task automatic set_lk(input logic [15:0] a, input logic [38:0] va);
        lk_valid = 1; lk_asid = a; lk_vaddr = va;
    endtask

    task automatic set_flush(input bit ua, input logic [15:0] a, input bit ud, input logic [38:0] va);
        flush_valid = 1; flush_use_asid = ua; flush_asid = a; flush_use_addr = ud; flush_vaddr = va;
    endtask

    function automatic logic [38:0] rnd_va();
        return {9'(5 + $urandom_range(0, 1)), 9'($urandom_range(0, 1)),
                9'(3 + $urandom_range(0, 1)), 12'($urandom)};
    endfunction

    initial begin
        #(20ns * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NE; i++) m_val[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        set_lk(16'd5, 39'h12_3456_7abc); step("R1 empty miss");

        // 4 KiB page, identifier gating
        set_fill(16'd5, 0, 2'd0, 39'h00_0040_3fff, 56'hab_cdef_0123_4fff, 8'hcf); step("R4 fill4k");
        set_lk(16'd5, 39'h00_0040_3123); step("R4 hit4k");
        set_lk(16'd6, 39'h00_0040_3123); step("R3 other asid");
        set_lk(16'd5, 39'h00_0040_4123); step("R4 next page miss");

        // 1 GiB global page; lookup same cycle as a fill (R12)
        set_fill(16'd7, 1, 2'd2, 39'h40_1234_5678, 56'h77_5555_5555_5555, 8'h5f);
        set_lk(16'd9, 39'h40_2abc_def0); step("R12 lookup with fill");
        set_lk(16'd9, 39'h40_2abc_def0); step("R3 R4 global giga");
        // 2 MiB page
        set_fill(16'd7, 0, 2'd1, 39'h01_0060_0000, 56'h12_3456_789a_bcde, 8'h0b); step("R4 fill2m");
        set_lk(16'd7, 39'h01_007f_fabc); step("R4 hit2m");

        // Flush by identifier keeps the global entry
        set_flush(1, 16'd7, 0, '0); set_lk(16'd7, 39'h01_007f_fabc); step("R12 lookup with flush");
        set_lk(16'd7, 39'h01_007f_fabc); step("R8 asid flush");
        set_lk(16'd3, 39'h40_0000_0001); step("R8 global survives");
        // Flush by address removes the global entry
        set_flush(0, '0, 1, 39'h40_3000_0000); step("R7 addr flush");
        set_lk(16'd3, 39'h40_0000_0001); step("R7 global gone");
        set_lk(16'd5, 39'h00_0040_3000); step("R7 other kept");
        // Both: wrong identifier keeps, right identifier removes
        set_flush(1, 16'd6, 1, 39'h00_0040_3000); step("R9 wrong asid");
        set_lk(16'd5, 39'h00_0040_3000); step("R9 kept");
        set_flush(1, 16'd5, 1, 39'h00_0040_3000); step("R9 both flush");
        set_lk(16'd5, 39'h00_0040_3000); step("R9 removed");

        // Flush all with a fill in the same cycle
        set_fill(16'd1, 1, 2'd0, 39'h00_0000_1000, 56'h1000, 8'h01); step("R6 prep");
        set_flush(0, '0, 0, '0);
        set_fill(16'd1, 1, 2'd0, 39'h00_0000_2000, 56'h2000, 8'h01); step("R11 flush+fill");
        set_lk(16'd1, 39'h00_0000_1000); step("R6 all gone");
        set_lk(16'd1, 39'h00_0000_2000); step("R11 fill dropped");

        // Replacement: five fills into four slots, first one evicted
        for (int i = 0; i < 5; i++) begin
            set_fill(16'd2, 0, 2'd0, 39'(64'h10000 + 64'(i) * 64'h1000), 56'(64'h900000 + 64'(i) * 64'h1000), 8'(i));
            step("R10 fill");
        end
        set_lk(16'd2, 39'h10000); step("R10 oldest evicted");
        set_lk(16'd2, 39'h11000); step("R10 second kept");
        set_lk(16'd2, 39'h14000); step("R10 newest present");

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 99) < 80) set_lk(16'($urandom_range(1, 2)), rnd_va());
            if ($urandom_range(0, 99) < 35)
                set_fill(16'($urandom_range(1, 2)), $urandom_range(0, 3) == 0,
                         2'($urandom_range(0, 2)), rnd_va(),
                         {24'($urandom), 32'($urandom)}, 8'($urandom));
            if ($urandom_range(0, 99) < 8)
                set_flush($urandom_range(0, 1) == 1, 16'($urandom_range(1, 2)),
                          $urandom_range(0, 1) == 1, rnd_va());
            step("R3 R4 R7 R8 R9 R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule